// File: doc/BRIEF.md
# DSP Power Mode Sequencer

This block sequences the power domain of a DSP core that sits beside a host processor. The host asks for a pause of one of three grades, or for a resume. The block answers by driving the DSP clock enable, a two-bit supply level select towards an external regulator interface, and the power switch enable. For the deepest grade it also runs a level handshake with a context backup engine before power-off, and one with a context restore engine after power-up.

A short pause only gates the clock and keeps the supply high. A middle pause gates the clock and lowers the supply to its floor, which costs one regulator settle time on entry and one on exit. A long pause first waits for the DSP to report the end of its current frame. It then requests a backup and opens the power switch once the backup is reported done. On resume from power-off, the switch closes and a settle count must expire before the restore is requested. Once the restore is done, a one-cycle DSP start pulse is issued and the domain is back in active mode. The settle time is a cycle count loaded from an input. A pause that arrives while a transition is running is kept and acted on when the block is active again.

Top module: `dps_pwr_seq`

## Requirements
- R1: After reset, modeSt is 0 (active), clkEn and pwrEn are 1, vSel is 0, settleReady is 1, and bkpReq, rstrReq and dspStart are 0. Mode codes: 0 active, 1 clock gated at high supply, 2 clock gated at low supply, 3 powered off, 4 in transition.
- R2: pauseGrade 1 (short) in active mode gives modeSt 1 with clkEn 0, vSel 0 (1.2 V) and pwrEn 1 from the next cycle. resumeReq in that mode returns to modeSt 0 with clkEn 1 on the next cycle.
- R3: pauseGrade 2 (middle) in active mode drives vSel 2 (0.9 V) with clkEn 0 and modeSt 4 for settleCycles+1 cycles, then modeSt 2. resumeReq in mode 2 drives the active supply code with clkEn 0 for settleCycles+1 cycles, then modeSt 0.
- R4: pauseGrade 3 (long) in active mode gives modeSt 4 with the clock still running, and bkpReq stays 0 until frameDone is seen.
- R5: The cycle after frameDone, bkpReq rises and holds until bkpDone. The cycle after bkpDone, bkpReq and pwrEn fall together, clkEn is 0 and modeSt is 3. pwrEn never falls without a preceding bkpDone.
- R6: resumeReq in mode 3 sets pwrEn to 1 with clkEn 0 on the next cycle. rstrReq rises exactly settleCycles+1 cycles later, never before the settle count is zero.
- R7: The cycle after rstrDone, rstrReq is 0 and dspStart is 1 for exactly one cycle, and modeSt is 0 on the cycle after that.
- R8: Every settle wait loads settleCycles into a down counter. settleReady is 1 only while that counter is zero.
- R9: A nonzero pauseGrade seen while modeSt is 4 is kept and taken as a pause on the first active cycle that follows.
- R10: pauseGrade is ignored in modes 1, 2 and 3, and resumeReq is ignored in mode 0.
- R11: In active mode, vSel follows perfPoint one cycle later, with perfPoint 3 mapped to vSel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pauseGrade | input | 2 | 0 none, 1 short, 2 middle, 3 long pause request |
| resumeReq | input | 1 | Resume request |
| frameDone | input | 1 | DSP reports end of current frame |
| bkpDone | input | 1 | Backup engine finished |
| rstrDone | input | 1 | Restore engine finished |
| perfPoint | input | 2 | Active operating point supply code |
| settleCycles | input | CNT_W | Regulator settle delay in cycles |
| clkEn | output | 1 | DSP clock enable |
| vSel | output | 2 | Supply level: 0 = 1.2 V, 1 = 1.0 V, 2 = 0.9 V |
| pwrEn | output | 1 | Power switch enable |
| bkpReq | output | 1 | Backup request (level) |
| rstrReq | output | 1 | Restore request (level) |
| dspStart | output | 1 | One-cycle DSP start pulse |
| settleReady | output | 1 | Settle counter at zero |
| modeSt | output | 3 | Current mode code |

## Verification
The bench builds the block with CNT_W set to 8. This lets the full-scale settle count of 255 be run next to the zero count, so both ends of every settle wait are reached in few cycles. Settle counts, handshake lags, operating points and idle pause requests are drawn at random around directed runs. The directed runs cover the zero and full-scale settle counts, pauses in gated modes, and a pause held across a restore.

// File: rtl/dps_pkg.sv
`timescale 1ns/1ps
package dps_pkg;
  localparam int VSEL_W  = 2;
  localparam int MODE_W  = 3;
  localparam int GRADE_W = 2;

  localparam logic [VSEL_W-1:0] VSEL_HIGH = 2'd0;
  localparam logic [VSEL_W-1:0] VSEL_LOW  = 2'd2;

  localparam logic [GRADE_W-1:0] GRADE_NONE   = 2'd0;
  localparam logic [GRADE_W-1:0] GRADE_SHORT  = 2'd1;
  localparam logic [GRADE_W-1:0] GRADE_MIDDLE = 2'd2;
  localparam logic [GRADE_W-1:0] GRADE_LONG   = 2'd3;

  localparam logic [MODE_W-1:0] MODE_ACTIVE = 3'd0;
  localparam logic [MODE_W-1:0] MODE_GATED  = 3'd1;
  localparam logic [MODE_W-1:0] MODE_LOWV   = 3'd2;
  localparam logic [MODE_W-1:0] MODE_OFF    = 3'd3;
  localparam logic [MODE_W-1:0] MODE_TRANS  = 3'd4;

  typedef enum logic [3:0] {
    ST_ACTIVE, ST_GATED, ST_LOWV_IN, ST_LOWV, ST_LOWV_OUT,
    ST_FRAME_WAIT, ST_BACKUP, ST_OFF, ST_POWER_UP, ST_RESTORE, ST_KICK
  } seqState_t;

  typedef struct packed {
    logic              loadCnt;
    logic              holdCap;
    logic              holdClr;
    logic              clkEn;
    logic              pwrEn;
    logic              forceLow;
    logic              forceHigh;
    logic              bkpReq;
    logic              rstrReq;
    logic              dspStart;
    logic [MODE_W-1:0] modeSt;
  } seqCmd_t;
endpackage

// File: rtl/dps_ctrl.sv
`timescale 1ns/1ps
module dps_ctrl
  import dps_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [GRADE_W-1:0] pauseGrade,
  input  logic               resumeReq,
  input  logic               frameDone,
  input  logic               bkpDone,
  input  logic               rstrDone,
  input  logic [GRADE_W-1:0] heldGrade,
  input  logic               cntZero,
  output seqCmd_t            cmd
);
  seqState_t state, nxt;
  logic [GRADE_W-1:0] effGrade;
  logic inTransit;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_ACTIVE;
    else       state <= nxt;
  end

  assign effGrade = (pauseGrade != GRADE_NONE) ? pauseGrade : heldGrade;

  always_comb begin
    case (state)
      ST_LOWV_IN, ST_LOWV_OUT, ST_FRAME_WAIT, ST_BACKUP,
      ST_POWER_UP, ST_RESTORE, ST_KICK: inTransit = 1'b1;
      default:                          inTransit = 1'b0;
    endcase
  end

  // next-state selection and strobes towards the datapath
  always_comb begin
    nxt = state;
    cmd = '0;
    cmd.holdCap = inTransit && (pauseGrade != GRADE_NONE);
    case (state)
      ST_ACTIVE: begin
        cmd.holdClr = 1'b1;
        case (effGrade)
          GRADE_SHORT:  nxt = ST_GATED;
          GRADE_MIDDLE: begin nxt = ST_LOWV_IN; cmd.loadCnt = 1'b1; end
          GRADE_LONG:   nxt = ST_FRAME_WAIT;
          default:      nxt = ST_ACTIVE;
        endcase
      end
      ST_GATED:      if (resumeReq) nxt = ST_ACTIVE;
      ST_LOWV_IN:    if (cntZero)   nxt = ST_LOWV;
      ST_LOWV:       if (resumeReq) begin nxt = ST_LOWV_OUT; cmd.loadCnt = 1'b1; end
      ST_LOWV_OUT:   if (cntZero)   nxt = ST_ACTIVE;
      ST_FRAME_WAIT: if (frameDone) nxt = ST_BACKUP;
      ST_BACKUP:     if (bkpDone)   nxt = ST_OFF;
      ST_OFF:        if (resumeReq) begin nxt = ST_POWER_UP; cmd.loadCnt = 1'b1; end
      ST_POWER_UP:   if (cntZero)   nxt = ST_RESTORE;
      ST_RESTORE:    if (rstrDone)  nxt = ST_KICK;
      ST_KICK:                      nxt = ST_ACTIVE;
      default:                      nxt = ST_ACTIVE;
    endcase

    // output levels for the state entered at the next edge
    cmd.pwrEn  = 1'b1;
    cmd.modeSt = MODE_TRANS;
    case (nxt)
      ST_ACTIVE:     begin cmd.clkEn = 1'b1; cmd.modeSt = MODE_ACTIVE; end
      ST_GATED:      begin cmd.forceHigh = 1'b1; cmd.modeSt = MODE_GATED; end
      ST_LOWV_IN:    cmd.forceLow = 1'b1;
      ST_LOWV:       begin cmd.forceLow = 1'b1; cmd.modeSt = MODE_LOWV; end
      ST_LOWV_OUT:   cmd.clkEn = 1'b0;
      ST_FRAME_WAIT: cmd.clkEn = 1'b1;
      ST_BACKUP:     begin cmd.clkEn = 1'b1; cmd.bkpReq = 1'b1; end
      ST_OFF:        begin cmd.pwrEn = 1'b0; cmd.forceLow = 1'b1; cmd.modeSt = MODE_OFF; end
      ST_POWER_UP:   cmd.clkEn = 1'b0;
      ST_RESTORE:    begin cmd.clkEn = 1'b1; cmd.rstrReq = 1'b1; end
      ST_KICK:       begin cmd.clkEn = 1'b1; cmd.dspStart = 1'b1; end
      default:       cmd.clkEn = 1'b1;
    endcase
  end
endmodule

// File: rtl/dps_dpath.sv
`timescale 1ns/1ps
module dps_dpath
  import dps_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqCmd_t            cmd,
  input  logic [CNT_W-1:0]   settleCycles,
  input  logic [VSEL_W-1:0]  perfPoint,
  input  logic [GRADE_W-1:0] pauseGrade,
  output logic               cntZero,
  output logic [GRADE_W-1:0] heldGrade,
  output logic               clkEn,
  output logic               pwrEn,
  output logic [VSEL_W-1:0]  vSel,
  output logic               bkpReq,
  output logic               rstrReq,
  output logic               dspStart,
  output logic [MODE_W-1:0]  modeSt
);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [VSEL_W-1:0] PERF_BAD = '1;

  logic [CNT_W-1:0]  settleCnt;
  logic [VSEL_W-1:0] activeV, nxtV;

  assign cntZero = (settleCnt == CNT_ZERO);
  assign activeV = (perfPoint == PERF_BAD) ? VSEL_HIGH : perfPoint;
  assign nxtV    = cmd.forceLow ? VSEL_LOW : (cmd.forceHigh ? VSEL_HIGH : activeV);

  always_ff @(posedge clk) begin
    if (!rstN)            settleCnt <= CNT_ZERO;
    else if (cmd.loadCnt) settleCnt <= settleCycles;
    else if (!cntZero)    settleCnt <= settleCnt - CNT_ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            heldGrade <= GRADE_NONE;
    else if (cmd.holdCap) heldGrade <= pauseGrade;
    else if (cmd.holdClr) heldGrade <= GRADE_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkEn    <= 1'b1;
      pwrEn    <= 1'b1;
      vSel     <= VSEL_HIGH;
      bkpReq   <= 1'b0;
      rstrReq  <= 1'b0;
      dspStart <= 1'b0;
      modeSt   <= MODE_ACTIVE;
    end else begin
      clkEn    <= cmd.clkEn;
      pwrEn    <= cmd.pwrEn;
      vSel     <= nxtV;
      bkpReq   <= cmd.bkpReq;
      rstrReq  <= cmd.rstrReq;
      dspStart <= cmd.dspStart;
      modeSt   <= cmd.modeSt;
    end
  end
endmodule

// File: rtl/dps_pwr_seq.sv
`timescale 1ns/1ps
module dps_pwr_seq
  import dps_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       pauseGrade,
  input  logic             resumeReq,
  input  logic             frameDone,
  input  logic             bkpDone,
  input  logic             rstrDone,
  input  logic [1:0]       perfPoint,
  input  logic [CNT_W-1:0] settleCycles,
  output logic             clkEn,
  output logic [1:0]       vSel,
  output logic             pwrEn,
  output logic             bkpReq,
  output logic             rstrReq,
  output logic             dspStart,
  output logic             settleReady,
  output logic [2:0]       modeSt
);
  seqCmd_t            cmd;
  logic               cntZero;
  logic [GRADE_W-1:0] heldGrade;

  dps_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .pauseGrade(pauseGrade), .resumeReq(resumeReq),
    .frameDone(frameDone), .bkpDone(bkpDone), .rstrDone(rstrDone),
    .heldGrade(heldGrade), .cntZero(cntZero), .cmd(cmd)
  );

  dps_dpath #(.CNT_W(CNT_W)) uDpath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .settleCycles(settleCycles),
    .perfPoint(perfPoint), .pauseGrade(pauseGrade), .cntZero(cntZero),
    .heldGrade(heldGrade), .clkEn(clkEn), .pwrEn(pwrEn), .vSel(vSel),
    .bkpReq(bkpReq), .rstrReq(rstrReq), .dspStart(dspStart), .modeSt(modeSt)
  );

  assign settleReady = cntZero;
endmodule

// File: rtl/dps_pwr_seq_chk.sv
`timescale 1ns/1ps
module dps_pwr_seq_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       pauseGrade,
  input logic             resumeReq,
  input logic             frameDone,
  input logic             bkpDone,
  input logic             rstrDone,
  input logic [1:0]       perfPoint,
  input logic [CNT_W-1:0] settleCycles,
  input logic             clkEn,
  input logic [1:0]       vSel,
  input logic             pwrEn,
  input logic             bkpReq,
  input logic             rstrReq,
  input logic             dspStart,
  input logic             settleReady,
  input logic [2:0]       modeSt
);
  AST_GATED_HIGH_V: assert property (@(posedge clk) disable iff (!rstN)
    (modeSt == 3'd1) |-> (!clkEn && vSel == 2'd0 && pwrEn)); // R2
  AST_LOWV_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (modeSt == 3'd2) |-> (!clkEn && vSel == 2'd2)); // R3
  AST_BKP_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bkpReq) |-> $past(frameDone)); // R4
  AST_PWR_OFF_AFTER_BKP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pwrEn) |-> ($past(bkpDone) && $past(bkpReq))); // R5
  AST_OFF_STATE: assert property (@(posedge clk) disable iff (!rstN)
    (modeSt == 3'd3) |-> (!pwrEn && !clkEn)); // R5
  AST_RSTR_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstrReq) |-> (pwrEn && settleReady)); // R6
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    dspStart |=> !dspStart); // R7
  AST_START_AFTER_RSTR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dspStart) |-> $past(rstrDone)); // R7
  AST_MODE_CODE: assert property (@(posedge clk) disable iff (!rstN)
    modeSt <= 3'd4); // R1
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({bkpReq, rstrReq, dspStart})); // R5
endmodule

bind dps_pwr_seq dps_pwr_seq_chk #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .pauseGrade(pauseGrade), .resumeReq(resumeReq),
  .frameDone(frameDone), .bkpDone(bkpDone), .rstrDone(rstrDone),
  .perfPoint(perfPoint), .settleCycles(settleCycles), .clkEn(clkEn),
  .vSel(vSel), .pwrEn(pwrEn), .bkpReq(bkpReq), .rstrReq(rstrReq),
  .dspStart(dspStart), .settleReady(settleReady), .modeSt(modeSt)
);

// File: tb/dps_pwr_seq_test.sv
`timescale 1ns/1ps
module dps_pwr_seq_test;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] pauseGrade = 2'd0;
  logic resumeReq = 1'b0, frameDone = 1'b0, bkpDone = 1'b0, rstrDone = 1'b0;
  logic [1:0] perfPoint = 2'd0;
  logic [CW-1:0] settleCycles = '0;
  logic clkEn, pwrEn, bkpReq, rstrReq, dspStart, settleReady;
  logic [1:0] vSel;
  logic [2:0] modeSt;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  dps_pwr_seq #(.CNT_W(CW)) uut (
    .clk(clk), .rstN(rstN), .pauseGrade(pauseGrade), .resumeReq(resumeReq),
    .frameDone(frameDone), .bkpDone(bkpDone), .rstrDone(rstrDone),
    .perfPoint(perfPoint), .settleCycles(settleCycles), .clkEn(clkEn),
    .vSel(vSel), .pwrEn(pwrEn), .bkpReq(bkpReq), .rstrReq(rstrReq),
    .dspStart(dspStart), .settleReady(settleReady), .modeSt(modeSt)
  );

  function automatic int expV(int pp);
    return (pp == 3) ? 0 : pp;
  endfunction

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask
  task automatic pulseGrade(int g); pauseGrade = 2'(g); tick(); pauseGrade = 2'd0; endtask
  task automatic pulseResume(); resumeReq = 1'b1; tick(); resumeReq = 1'b0; endtask
  task automatic pulseFrame(); frameDone = 1'b1; tick(); frameDone = 1'b0; endtask
  task automatic pulseBkp(); bkpDone = 1'b1; tick(); bkpDone = 1'b0; endtask
  task automatic pulseRstr(); rstrDone = 1'b1; tick(); rstrDone = 1'b0; endtask

  task automatic doShort();
    pulseGrade(1);
    chk("R2 mode gated", modeSt, 1);
    chk("R2 clkEn", clkEn, 0);
    chk("R2 vSel high", vSel, 0);
    chk("R2 pwrEn", pwrEn, 1);
    pulseGrade(2);
    chk("R10 pause ignored in gated", modeSt, 1);
    pulseResume();
    chk("R2 back active", modeSt, 0);
    chk("R2 clkEn on", clkEn, 1);
    tick();
    chk("R10 ignored pause not held", modeSt, 0);
  endtask

  task automatic doMiddle(int n, int pp);
    settleCycles = CW'(n);
    pulseGrade(2);
    chk("R3 entering", modeSt, 4);
    chk("R3 low supply", vSel, 2);
    chk("R3 clock gated", clkEn, 0);
    chk("R8 ready while loaded", settleReady, (n == 0) ? 1 : 0);
    repeat (n) tick();
    chk("R3 still settling", modeSt, 4);
    chk("R8 ready at zero", settleReady, 1);
    tick();
    chk("R3 low mode", modeSt, 2);
    pulseGrade(1);
    chk("R10 pause ignored in low", modeSt, 2);
    perfPoint = 2'(pp);
    pulseResume();
    chk("R3 exiting", modeSt, 4);
    chk("R3 exit supply", vSel, expV(pp));
    chk("R3 exit gated", clkEn, 0);
    repeat (n) tick();
    chk("R3 exit settling", modeSt, 4);
    tick();
    chk("R3 active again", modeSt, 0);
    chk("R3 clock on", clkEn, 1);
    chk("R11 active supply", vSel, expV(pp));
  endtask

  task automatic doLong(int n, int fl, int bl, int rl, int idle, bit doHold);
    settleCycles = CW'(n);
    pulseGrade(3);
    chk("R4 transit", modeSt, 4);
    chk("R4 clock runs", clkEn, 1);
    chk("R4 no backup yet", bkpReq, 0);
    repeat (fl) tick();
    chk("R4 waits frame", bkpReq, 0);
    pulseFrame();
    chk("R5 backup req", bkpReq, 1);
    repeat (bl) tick();
    chk("R5 power kept", pwrEn, 1);
    chk("R5 backup held", bkpReq, 1);
    pulseBkp();
    chk("R5 off mode", modeSt, 3);
    chk("R5 power off", pwrEn, 0);
    chk("R5 clock off", clkEn, 0);
    chk("R5 backup drop", bkpReq, 0);
    for (int i = 0; i < idle; i++) begin
      pulseGrade(1 + int'($urandom_range(2)));
      chk("R10 pause ignored off", modeSt, 3);
    end
    pulseResume();
    chk("R6 power on", pwrEn, 1);
    chk("R6 clock gated", clkEn, 0);
    chk("R6 no restore", rstrReq, 0);
    chk("R8 counting", settleReady, (n == 0) ? 1 : 0);
    repeat (n) tick();
    chk("R6 before settle", rstrReq, 0);
    tick();
    chk("R6 restore req", rstrReq, 1);
    chk("R8 ready", settleReady, 1);
    if (doHold) pulseGrade(1);
    repeat (rl) tick();
    pulseRstr();
    chk("R7 start pulse", dspStart, 1);
    chk("R7 restore drop", rstrReq, 0);
    tick();
    chk("R7 one cycle", dspStart, 0);
    chk("R7 active", modeSt, 0);
    tick();
    if (doHold) begin
      chk("R9 held pause taken", modeSt, 1);
      pulseResume();
      chk("R9 resume after held", modeSt, 0);
    end else begin
      chk("R9 nothing held", modeSt, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240));
    repeat (3) tick();
    rstN = 1'b1;
    chk("R1 mode", modeSt, 0);
    chk("R1 clkEn", clkEn, 1);
    chk("R1 pwrEn", pwrEn, 1);
    chk("R1 vSel", vSel, 0);
    chk("R1 settleReady", settleReady, 1);
    chk("R1 requests", {bkpReq, rstrReq, dspStart}, 0);

    perfPoint = 2'd1; tick(); chk("R11 point 1", vSel, 1);
    perfPoint = 2'd3; tick(); chk("R11 point 3 maps", vSel, 0);
    perfPoint = 2'd2; tick(); chk("R11 point 2", vSel, 2);
    perfPoint = 2'd0; tick();

    pulseResume();
    chk("R10 resume ignored active", modeSt, 0);
    chk("R10 clock kept", clkEn, 1);

    doShort();
    doMiddle(0, 1);
    doMiddle(255, 3);
    doLong(0, 0, 0, 0, 0, 1'b0);
    doLong(3, 2, 1, 2, 2, 1'b1);

    for (int k = 0; k < 24; k++) begin
      int op = int'($urandom_range(2));
      int n  = int'($urandom_range(20));
      if (op == 0) doShort();
      else if (op == 1) doMiddle(n, int'($urandom_range(3)));
      else doLong(n, int'($urandom_range(4)), int'($urandom_range(4)),
                  int'($urandom_range(4)), int'($urandom_range(3)),
                  1'($urandom_range(1)));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule